// File: doc/BRIEF.md
# Midpoint Sampling Strobe Generator

This block produces the non-uniform sampling strobe for one receive channel of a delay-and-sum beamformer. Along a scan line, the focusing delay of an element shrinks by one quantisation step at a time. The block follows that change with an incremental midpoint decision. It keeps a signed decision value and two signed increments, and it updates them using only two-input multiplexers and two-input adders. It uses no multiplier and no square root.

Software or a sequencer first loads the start values: the decision value, both increments, the starting delay count and a step constant K. The block derives the 8K and 16K-8 constants from K once at load time and holds them in registers. A start pulse then arms a run of a programmed number of range steps. Each accepted tick of the clock-enable input performs one update. Every update raises a one-cycle base strobe. An update taken with a positive decision also lowers the delay count and adds a second, separate one-cycle strobe. One update covers K focal points.

Top module: `nus_strobe_gen`

## Requirements
- R1: After reset, `sampleStrobe` is low, `busy` is low and `delayOut` is zero.
- R2: A `loadPulse` while `busy` is low captures the decision value, both increments, the delay count and K, and `delayOut` shows the new count on the next cycle. A `loadPulse` while `busy` is high has no effect.
- R3: On an update whose decision value is zero or negative, the next decision is d + A, A is unchanged and B is lowered by 8K.
- R4: On an update whose decision value is positive (sign bit clear and nonzero), the next decision is d + B, A is lowered by 8K and B is lowered by 16K - 8.
- R5: The branch of each update comes from a registered positive flag of the current decision value, and that flag also selects the increment added on the same update.
- R6: An update taken at edge t drives `sampleStrobe` high for exactly the cycle after t. A positive update adds one more one-cycle pulse two cycles after the base pulse, with one low cycle between the two.
- R7: A positive update lowers the delay count by one, and the count saturates at zero. The new count is visible on `delayOut` in the cycle of the base pulse. The count changes at no other time except a load.
- R8: A `startPulse` while idle with a nonzero `stepCount` raises `busy` on the next cycle. The run then performs exactly `stepCount` updates, and `busy` falls right after the last one. A start with a zero count, or a start while busy, is ignored.
- R9: A `tickEn` that arrives while a strobe pulse is still pending or on the line is dropped and does not update. Successive pulses therefore always stay separated by a low cycle.
- R10: The decision value and both increments are 24-bit two's-complement registers that wrap on overflow, and the positive flag is taken from the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadPulse | input | 1 | Capture start values (idle only) |
| startPulse | input | 1 | Arm a run of `stepCount` updates |
| tickEn | input | 1 | Range-step enable; one update per accepted tick |
| initDec | input | 24 | Initial decision value, signed |
| initIncA | input | 24 | Initial increment A, signed |
| initIncB | input | 24 | Initial increment B, signed |
| initDelay | input | 16 | Initial delay count |
| stepK | input | 8 | Step constant K, unsigned |
| stepCount | input | 8 | Number of updates in a run |
| sampleStrobe | output | 1 | Sampling strobe (base and extra pulses) |
| delayOut | output | 16 | Current delay count |
| busy | output | 1 | High while a run is in progress |

## Verification
Two things can fall in the same cycle: a new range tick and a strobe pulse that is still pending, whether it is the base pulse or the extra pulse of a positive update. One run strobes `tickEn` twice in a row, so that every second tick lands on the base pulse. Another run holds `tickEn` high throughout, so that ticks also land in the gap and on the extra pulse. The scoreboard judges both runs the same way. It predicts the decision sequence and delay values from R3, R4 and R10 alone. It then demands that every base pulse carry the next expected delay, that every pulse be flanked by low cycles, and that no base pulse appear beyond the programmed count.

// File: rtl/nus_pkg.sv
package nus_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;  // capture start values
    logic step;  // perform one midpoint update
  } nusCtl_t;

endpackage

// File: rtl/nus_dpath.sv
module nus_dpath
  import nus_pkg::*;
#(
  parameter int W  = 24,
  parameter int DW = 16,
  parameter int KW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nusCtl_t              ctl,
  input  logic signed [W-1:0]  initDec,
  input  logic signed [W-1:0]  initIncA,
  input  logic signed [W-1:0]  initIncB,
  input  logic [DW-1:0]        initDelay,
  input  logic [KW-1:0]        stepK,
  output logic                 dPos,
  output logic [DW-1:0]        delayOut
);

  localparam int PadW = W - KW;

  logic signed [W-1:0] dReg, aReg, bReg;
  logic signed [W-1:0] c8Reg, c16Reg;
  logic [DW-1:0]       delayReg;
  logic                posReg;

  logic signed [W-1:0] kWide, c8Next, c16Next;
  logic signed [W-1:0] incSel, dNext;
  logic [DW-1:0]       delayDec;

  function automatic logic isPos(input logic signed [W-1:0] v);
    return !v[W-1] && (v != '0);
  endfunction

  // Constants derived once at load time.
  assign kWide   = {{PadW{1'b0}}, stepK};
  assign c8Next  = kWide <<< 3;
  assign c16Next = (kWide <<< 4) - W'(8);

  // The registered flag picks the increment: one mux, then one adder.
  assign incSel = posReg ? bReg : aReg;
  assign dNext  = dReg + incSel;

  assign delayDec = (delayReg == '0) ? delayReg : delayReg - DW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dReg     <= '0;
      aReg     <= '0;
      bReg     <= '0;
      c8Reg    <= '0;
      c16Reg   <= '0;
      delayReg <= '0;
      posReg   <= 1'b0;
    end else if (ctl.load) begin
      dReg     <= initDec;
      aReg     <= initIncA;
      bReg     <= initIncB;
      c8Reg    <= c8Next;
      c16Reg   <= c16Next;
      delayReg <= initDelay;
      posReg   <= isPos(initDec);
    end else if (ctl.step) begin
      dReg   <= dNext;
      posReg <= isPos(dNext);
      if (posReg) begin
        aReg     <= aReg - c8Reg;
        bReg     <= bReg - c16Reg;
        delayReg <= delayDec;
      end else begin
        bReg <= bReg - c8Reg;
      end
    end
  end

  assign dPos     = posReg;
  assign delayOut = delayReg;

endmodule

// File: rtl/nus_ctrl.sv
module nus_ctrl
  import nus_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadPulse,
  input  logic          startPulse,
  input  logic          tickEn,
  input  logic [CW-1:0] stepCount,
  input  logic          dPos,
  output nusCtl_t       ctl,
  output logic          sampleStrobe,
  output logic          busy
);

  // Pulse shaper: bit 0 drives the line; a step loads {extra, gap, base}.
  localparam int SrW = 3;

  logic          running;
  logic [CW-1:0] remaining;
  logic [SrW-1:0] pulseSr;
  logic          acceptStart, stepGo;

  assign acceptStart = startPulse && !running && (stepCount != '0);
  assign stepGo      = running && tickEn && (pulseSr == '0);

  always_comb begin
    ctl      = '0;
    ctl.load = loadPulse && !running;
    ctl.step = stepGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      remaining <= '0;
      pulseSr   <= '0;
    end else begin
      if (acceptStart) begin
        running   <= 1'b1;
        remaining <= stepCount;
      end else if (stepGo) begin
        remaining <= remaining - CW'(1);
        if (remaining == CW'(1)) running <= 1'b0;
      end

      if (stepGo) pulseSr <= {dPos, 1'b0, 1'b1};
      else        pulseSr <= pulseSr >> 1;
    end
  end

  assign sampleStrobe = pulseSr[0];
  assign busy         = running;

endmodule

// File: rtl/nus_strobe_gen.sv
module nus_strobe_gen
  import nus_pkg::*;
#(
  parameter int W  = 24,
  parameter int DW = 16,
  parameter int KW = 8,
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadPulse,
  input  logic                startPulse,
  input  logic                tickEn,
  input  logic signed [W-1:0] initDec,
  input  logic signed [W-1:0] initIncA,
  input  logic signed [W-1:0] initIncB,
  input  logic [DW-1:0]       initDelay,
  input  logic [KW-1:0]       stepK,
  input  logic [CW-1:0]       stepCount,
  output logic                sampleStrobe,
  output logic [DW-1:0]       delayOut,
  output logic                busy
);

  nusCtl_t ctl;
  logic    dPos;

  nus_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .loadPulse   (loadPulse),
    .startPulse  (startPulse),
    .tickEn      (tickEn),
    .stepCount   (stepCount),
    .dPos        (dPos),
    .ctl         (ctl),
    .sampleStrobe(sampleStrobe),
    .busy        (busy)
  );

  nus_dpath #(.W(W), .DW(DW), .KW(KW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .initDec  (initDec),
    .initIncA (initIncA),
    .initIncB (initIncB),
    .initDelay(initDelay),
    .stepK    (stepK),
    .dPos     (dPos),
    .delayOut (delayOut)
  );

endmodule

// File: rtl/nus_checker.sv
module nus_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          loadPulse,
  input logic          startPulse,
  input logic          busy,
  input logic          sampleStrobe,
  input logic [DW-1:0] delayOut,
  input logic          stepPulse,
  input logic          loadAcc
);

  assert_load_blocked_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy && loadPulse |-> !loadAcc);

  assert_strobe_follows_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |=> sampleStrobe);

  assert_delay_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse && (delayOut == '0) |=> delayOut == '0);

  assert_delay_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stepPulse && !loadAcc |=> $stable(delayOut));

  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !startPulse |=> !busy);

  assert_busy_ends_on_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(stepPulse));

  assert_no_step_on_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> !stepPulse);

endmodule

bind nus_strobe_gen nus_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .loadPulse   (loadPulse),
  .startPulse  (startPulse),
  .busy        (busy),
  .sampleStrobe(sampleStrobe),
  .delayOut    (delayOut),
  .stepPulse   (ctl.step),
  .loadAcc     (ctl.load)
);

// File: tb/test_nus_strobe_gen.sv
`timescale 1ns/1ps
module test_nus_strobe_gen;

  localparam int W = 24, DW = 16, KW = 8, CW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic loadPulse = 0, startPulse = 0, tickEn = 0;
  logic signed [W-1:0] initDec = '0, initIncA = '0, initIncB = '0;
  logic [DW-1:0] initDelay = '0;
  logic [KW-1:0] stepK = '0;
  logic [CW-1:0] stepCount = '0;
  logic sampleStrobe, busy;
  logic [DW-1:0] delayOut;

  always #2.5 clk = ~clk;

  nus_strobe_gen #(.W(W), .DW(DW), .KW(KW), .CW(CW)) i_nus_strobe_gen (
    .clk(clk), .rstN(rstN), .loadPulse(loadPulse), .startPulse(startPulse),
    .tickEn(tickEn), .initDec(initDec), .initIncA(initIncA), .initIncB(initIncB),
    .initDelay(initDelay), .stepK(stepK), .stepCount(stepCount),
    .sampleStrobe(sampleStrobe), .delayOut(delayOut), .busy(busy));

  typedef struct { bit pos; logic [DW-1:0] dly; } expItem_t;
  expItem_t expQ[$];

  int checks = 0, errors = 0;
  logic signed [W-1:0] mD, mA, mB;
  logic [DW-1:0] mDly;
  logic [KW-1:0] mK;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model of one update, written from R3, R4, R7 and R10.
  task automatic modelStep();
    expItem_t it;
    logic signed [W-1:0] k8, k16;
    k8  = W'(mK) * 8;
    k16 = W'(mK) * 16 - 8;
    it.pos = (mD > 0);
    if (it.pos) begin
      mD = mD + mB; mA = mA - k8; mB = mB - k16;
      if (mDly != 0) mDly = mDly - 1;
    end else begin
      mD = mD + mA; mB = mB - k8;
    end
    it.dly = mDly;
    expQ.push_back(it);
  endtask

  task automatic doLoad(input logic signed [W-1:0] d, a, b, input logic [DW-1:0] dl,
                        input logic [KW-1:0] k);
    @(negedge clk);
    initDec = d; initIncA = a; initIncB = b; initDelay = dl; stepK = k;
    loadPulse = 1;
    @(negedge clk);
    loadPulse = 0;
    mD = d; mA = a; mB = b; mDly = dl; mK = k;
    check(delayOut == dl, "R2 load delay", delayOut, dl);
  endtask

  // mode 0: spaced ticks, each followed by a stray tick (R9)
  // mode 1: tickEn held high, with a start and a load mid-run (R2, R8, R9)
  task automatic runSteps(input int n, input int mode);
    for (int i = 0; i < n; i++) modelStep();
    @(negedge clk);
    stepCount = CW'(n); startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    check(busy == 1'b1, "R8 busy rises", busy, 1);
    if (mode == 0) begin
      for (int i = 0; i < n; i++) begin
        tickEn = 1;
        @(negedge clk);
        tickEn = 1;
        @(negedge clk);
        tickEn = 0;
        repeat (5) @(negedge clk);
      end
    end else begin
      tickEn = 1;
      repeat (3) @(negedge clk);
      stepCount = CW'(9); startPulse = 1;
      initDec = 24'sd5; initIncA = 24'sd9; initIncB = 24'sd9; initDelay = 16'd999;
      loadPulse = 1;
      @(negedge clk);
      startPulse = 0; loadPulse = 0;
      for (int i = 0; i < 400 && busy; i++) @(negedge clk);
      tickEn = 0;
    end
    repeat (8) @(negedge clk);
    check(busy == 1'b0, "R8 busy falls", busy, 0);
    check(expQ.size() == 0, "R8 update count", expQ.size(), 0);
  endtask

  // Monitor: pops one expected item per base pulse.
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rstN && sampleStrobe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected base pulse", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(delayOut == e.dly, "R7 delay at base pulse", delayOut, e.dly);
          @(negedge clk);
          check(!sampleStrobe, "R6 gap after base", sampleStrobe, 0);
          if (e.pos) begin
            @(negedge clk);
            check(sampleStrobe, "R4 R5 extra pulse", sampleStrobe, 1);
            @(negedge clk);
            check(!sampleStrobe, "R9 gap after extra", sampleStrobe, 0);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(sampleStrobe == 0, "R1 strobe", sampleStrobe, 0);
    check(busy == 0, "R1 busy", busy, 0);
    check(delayOut == 0, "R1 delay", delayOut, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R6 R9: mixed decisions, stray ticks dropped
    doLoad(-24'sd5, 24'sd20, -24'sd30, 16'd10, 8'd1);
    runSteps(8, 0);

    // R2 R7 R8 R9: saturating delay, continuous ticks, ignored start and load
    doLoad(24'sd7, 24'sd100, -24'sd3, 16'd2, 8'd1);
    runSteps(12, 1);

    // R10: d + B overflows to a negative value
    doLoad(24'sh7FFFF0, 24'sd0, 24'sh7FFFFF, 16'd50, 8'd2);
    runSteps(4, 0);

    // R3 R4 with a larger K
    doLoad(24'sd40, -24'sd3, 24'sd10, 16'd300, 8'd5);
    runSteps(10, 1);

    // R8: a start with a zero count is ignored
    @(negedge clk);
    stepCount = '0; startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    check(busy == 0, "R8 zero count ignored", busy, 0);
    repeat (3) @(negedge clk);
    check(sampleStrobe == 0, "R8 no pulse after zero start", sampleStrobe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule